// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block is the in-flight tracking queue of a speculative out-of-order core. Every operation issued by the front end claims one slot at the tail of a circular queue of 40 slots. The slot number comes back as a tag, and that tag is the rename name used downstream. Execution units send results back by that tag, in any order. The queue retires finished slots from its head strictly in program order, at most three per cycle. It drives a register write lane for each retiring slot that names an architectural register, and a store request lane for each retiring slot that targets memory.

Two events at the head cut the queue short:

- **Mispredicted branch.** A branch that was executed with a mispredict flag retires normally. Every slot younger than it is discarded, and a flush strobe tells the front end to restart on the right path.
- **Exception.** A slot that reports an exception is not retired and changes no architectural state. It is discarded together with everything younger, and the flush is marked as an exception flush.

Commit outputs depend only on the registered queue state. A writeback therefore makes its slot retirable from the next cycle on. Retirement and flushing take effect at the following clock edge. Reset is asynchronous and active low, and its release is expected to be synchronous to `clk`.

Top module: `reorder_queue`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `cm_valid` is 0, `flush` is 0 and `alloc_tag` is 0.
- R2: An accepted allocation takes the slot shown on `alloc_tag`. Successive allocations get tags 0, 1, ... 39 and then wrap to 0.
- R3: `full` is 1 exactly when 40 slots are occupied. An allocation request while `full` is 1 is ignored: no slot is taken and `alloc_tag` does not move.
- R4: A writeback marks the slot named by `wb_tag` as finished and stores its value, address and flags. Only a finished slot whose older slots have all retired may retire, so finished slots behind an unfinished oldest slot wait.
- R5: Up to 3 slots retire per cycle. Lane 0 carries the oldest, and the retiring lanes are contiguous from lane 0. `cm_tag` gives each retiring lane's slot tag.
- R6: The destination kind decides what a retiring slot writes. Kind 1 (register) raises `cm_reg_we` with the slot's register index and value. Kind 2 (memory) raises `cm_st_req` with the slot's address and value on the data lane. Kind 0 (none) raises neither.
- R7: A retiring slot of operation type 2 (branch) that carries the mispredict flag retires, raises `flush` in the same cycle, and stops the younger lanes. All younger slots are discarded, and the next tag handed out is the branch tag plus one, modulo 40.
- R8: When the oldest unretired slot that is allowed to retire carries the exception flag, it does not retire and writes nothing. `flush` and `flush_exc` are raised, older slots in the same cycle still retire, and all slots are discarded. The next tag handed out is the excepting slot's tag.
- R9: An allocation request in a cycle where `flush` is 1 is discarded.
- R10: The mispredict flag on a slot whose operation type is not branch (types 0 register op and 1 store) has no effect: the slot retires normally and no flush occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to allocate a slot for a newly issued operation |
| alloc_op | input | 2 | Operation type: 0 register op, 1 store, 2 branch |
| alloc_dst | input | 2 | Destination kind: 0 none, 1 register, 2 memory |
| alloc_areg | input | 4 | Architectural destination register index |
| alloc_tag | output | 6 | Tag of the slot the next allocation takes |
| full | output | 1 | All 40 slots occupied; allocation ignored |
| wb_valid | input | 1 | Result writeback strobe |
| wb_tag | input | 6 | Slot tag of the writeback |
| wb_data | input | 32 | Result value (store data for memory destinations) |
| wb_addr | input | 32 | Store address for memory destinations |
| wb_exc | input | 1 | Operation raised an exception |
| wb_misp | input | 1 | Branch was mispredicted |
| cm_valid | output | 3 | Per-lane retire strobes, lane 0 oldest |
| cm_tag | output | 18 | Per-lane slot tag, 6 bits per lane |
| cm_reg_we | output | 3 | Per-lane architectural register write enable |
| cm_reg_idx | output | 12 | Per-lane register index, 4 bits per lane |
| cm_data | output | 96 | Per-lane value for register write or store data |
| cm_st_req | output | 3 | Per-lane store request strobe |
| cm_st_addr | output | 96 | Per-lane store address |
| flush | output | 1 | Younger slots discarded this cycle; restart fetch |
| flush_exc | output | 1 | The flush is caused by an exception |

## Verification
The main stimulus is randomized out-of-order writeback against a bench model of the queue. It separates correct program-order retirement from retirement in writeback order, and it covers wrap-around of the tags. Directed patterns cover the remaining cases:

- Filling the queue completely and then issuing one more request distinguishes a correctly gated full state from an overrun.
- Writing back a young slot first and the oldest slot last shows whether the head blocks, and then whether three lanes retire together.
- Mispredict and exception sequences separate a branch that retires from an excepting slot that does not, and check where the tail restarts.
- An allocation presented during the flush cycle, and a mispredict flag on a non-branch operation, confirm that both are ignored.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    OPK_ALU    = 2'd0,
    OPK_STORE  = 2'd1,
    OPK_BRANCH = 2'd2,
    OPK_RSVD   = 2'd3
  } opk_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_REG  = 2'd1,
    DST_MEM  = 2'd2,
    DST_RSVD = 2'd3
  } dst_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 40,
  parameter int RET_W = 3,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NR_W  = $clog2(RET_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             flush,
  input  logic [NR_W-1:0]  nret,
  output logic [TAG_W-1:0] head_idx,
  output logic [TAG_W-1:0] tail_idx,
  output logic             full,
  output logic [CNT_W-1:0] used
);
  // pointer = {wrap, index}; index runs 0..DEPTH-1
  logic [TAG_W:0] head_q, head_d, tail_q, tail_d;

  function automatic logic [TAG_W:0] advance(input logic [TAG_W:0] p,
                                             input logic [NR_W-1:0] n);
    logic [TAG_W:0] s;
    logic [TAG_W:0] d;
    s = {1'b0, p[TAG_W-1:0]} + (TAG_W+1)'(n);
    d = s - (TAG_W+1)'(DEPTH);
    if (s >= (TAG_W+1)'(DEPTH)) advance = {~p[TAG_W], d[TAG_W-1:0]};
    else                        advance = {p[TAG_W], s[TAG_W-1:0]};
  endfunction

  always_comb begin
    head_d = advance(head_q, nret);
    if (flush)           tail_d = head_d;
    else if (alloc_fire) tail_d = advance(tail_q, NR_W'(1));
    else                 tail_d = tail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign head_idx = head_q[TAG_W-1:0];
  assign tail_idx = tail_q[TAG_W-1:0];
  assign full     = (head_idx == tail_idx) && (head_q[TAG_W] != tail_q[TAG_W]);
  assign used     = (head_q[TAG_W] == tail_q[TAG_W])
                  ? CNT_W'(tail_idx) - CNT_W'(head_idx)
                  : CNT_W'(DEPTH) - CNT_W'(head_idx) + CNT_W'(tail_idx);

  // R3: occupancy never exceeds the slot count
  p_used_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    used <= CNT_W'(DEPTH));

  // R3: full with nothing leaving keeps the tail in place
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && nret == '0 && !flush) |=> (full && tail_q == $past(tail_q)));

  // R7: a flush leaves the queue empty
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (used == '0));
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int DEPTH  = 40,
  parameter int RET_W  = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int AREG_W = 4,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_we,
  input  logic [TAG_W-1:0]        alloc_idx,
  input  logic [1:0]              alloc_op,
  input  logic [1:0]              alloc_dst,
  input  logic [AREG_W-1:0]       alloc_areg,
  input  logic                    wb_we,
  input  logic [TAG_W-1:0]        wb_idx,
  input  logic [DATA_W-1:0]       wb_data,
  input  logic [ADDR_W-1:0]       wb_addr,
  input  logic                    wb_exc,
  input  logic                    wb_misp,
  input  logic [TAG_W-1:0]        head_idx,
  output logic [RET_W*TAG_W-1:0]  lane_tag,
  output logic [RET_W-1:0]        lane_rdy,
  output logic [RET_W-1:0]        lane_exc,
  output logic [RET_W-1:0]        lane_misp,
  output logic [RET_W*2-1:0]      lane_op,
  output logic [RET_W*2-1:0]      lane_dst,
  output logic [RET_W*AREG_W-1:0] lane_areg,
  output logic [RET_W*DATA_W-1:0] lane_data,
  output logic [RET_W*ADDR_W-1:0] lane_addr
);
  logic [DEPTH-1:0]  rdy_q, exc_q, misp_q;
  logic [1:0]        op_m   [DEPTH];
  logic [1:0]        dst_m  [DEPTH];
  logic [AREG_W-1:0] areg_m [DEPTH];
  logic [DATA_W-1:0] data_m [DEPTH];
  logic [ADDR_W-1:0] addr_m [DEPTH];
  logic              wb_take;

  // allocation of a slot wins over a stray writeback to the same slot
  assign wb_take = wb_we && !(alloc_we && alloc_idx == wb_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= '0;
      exc_q  <= '0;
      misp_q <= '0;
    end else begin
      if (alloc_we) begin
        rdy_q[alloc_idx]  <= 1'b0;
        exc_q[alloc_idx]  <= 1'b0;
        misp_q[alloc_idx] <= 1'b0;
      end
      if (wb_take) begin
        rdy_q[wb_idx]  <= 1'b1;
        exc_q[wb_idx]  <= wb_exc;
        misp_q[wb_idx] <= wb_misp;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_we) begin
      op_m[alloc_idx]   <= alloc_op;
      dst_m[alloc_idx]  <= alloc_dst;
      areg_m[alloc_idx] <= alloc_areg;
    end
    if (wb_take) begin
      data_m[wb_idx] <= wb_data;
      addr_m[wb_idx] <= wb_addr;
    end
  end

  for (genvar g = 0; g < RET_W; g++) begin : g_lane
    logic [TAG_W:0]   sum;
    logic [TAG_W:0]   sub;
    logic [TAG_W-1:0] idx;
    assign sum = {1'b0, head_idx} + (TAG_W+1)'(g);
    assign sub = sum - (TAG_W+1)'(DEPTH);
    assign idx = (sum >= (TAG_W+1)'(DEPTH)) ? sub[TAG_W-1:0] : sum[TAG_W-1:0];
    assign lane_tag[g*TAG_W +: TAG_W]    = idx;
    assign lane_rdy[g]                   = rdy_q[idx];
    assign lane_exc[g]                   = exc_q[idx];
    assign lane_misp[g]                  = misp_q[idx];
    assign lane_op[g*2 +: 2]             = op_m[idx];
    assign lane_dst[g*2 +: 2]            = dst_m[idx];
    assign lane_areg[g*AREG_W +: AREG_W] = areg_m[idx];
    assign lane_data[g*DATA_W +: DATA_W] = data_m[idx];
    assign lane_addr[g*ADDR_W +: ADDR_W] = addr_m[idx];
  end

  // R4: an accepted writeback leaves its slot finished
  p_wb_marks_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_take |=> rdy_q[$past(wb_idx)]);

  // R2: a freshly allocated slot starts unfinished
  p_alloc_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_we && !wb_we) |=> !rdy_q[$past(alloc_idx)]);
endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
  parameter int RET_W = 3,
  parameter int CNT_W = 6,
  localparam int NR_W = $clog2(RET_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   used,
  input  logic [RET_W-1:0]   lane_rdy,
  input  logic [RET_W-1:0]   lane_exc,
  input  logic [RET_W-1:0]   lane_misp,
  input  logic [RET_W*2-1:0] lane_op,
  input  logic [RET_W*2-1:0] lane_dst,
  output logic [RET_W-1:0]   ret_valid,
  output logic [RET_W-1:0]   reg_we,
  output logic [RET_W-1:0]   st_req,
  output logic               flush,
  output logic               flush_exc,
  output logic [NR_W-1:0]    nret
);
  import rob_pkg::*;

  logic stop;

  always_comb begin
    ret_valid = '0;
    reg_we    = '0;
    st_req    = '0;
    flush     = 1'b0;
    flush_exc = 1'b0;
    nret      = '0;
    stop      = 1'b0;
    for (int i = 0; i < RET_W; i++) begin
      if (!stop && (CNT_W'(i) < used) && lane_rdy[i]) begin
        if (lane_exc[i]) begin
          flush     = 1'b1;
          flush_exc = 1'b1;
          stop      = 1'b1;
        end else begin
          ret_valid[i] = 1'b1;
          nret         = nret + NR_W'(1);
          reg_we[i]    = (lane_dst[i*2 +: 2] == DST_REG);
          st_req[i]    = (lane_dst[i*2 +: 2] == DST_MEM);
          if (lane_op[i*2 +: 2] == OPK_BRANCH && lane_misp[i]) begin
            flush = 1'b1;
            stop  = 1'b1;
          end
        end
      end else begin
        stop = 1'b1;
      end
    end
  end

  // R5: retiring lanes are contiguous from the oldest
  for (genvar g = 1; g < RET_W; g++) begin : g_chk
    p_inorder_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid[g] |-> ret_valid[g-1]);
  end

  // R6: no write of either kind without retirement
  p_write_needs_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_we | st_req) & ~ret_valid) == '0);

  // R8: an excepting slot never retires together with a younger lane
  p_exc_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_exc |-> !ret_valid[RET_W-1]);
endmodule

// File: rtl/reorder_queue.sv
module reorder_queue #(
  parameter int DEPTH  = 40,
  parameter int RET_W  = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int AREG_W = 4,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NR_W  = $clog2(RET_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_valid,
  input  logic [1:0]              alloc_op,
  input  logic [1:0]              alloc_dst,
  input  logic [AREG_W-1:0]       alloc_areg,
  output logic [TAG_W-1:0]        alloc_tag,
  output logic                    full,
  input  logic                    wb_valid,
  input  logic [TAG_W-1:0]        wb_tag,
  input  logic [DATA_W-1:0]       wb_data,
  input  logic [ADDR_W-1:0]       wb_addr,
  input  logic                    wb_exc,
  input  logic                    wb_misp,
  output logic [RET_W-1:0]        cm_valid,
  output logic [RET_W*TAG_W-1:0]  cm_tag,
  output logic [RET_W-1:0]        cm_reg_we,
  output logic [RET_W*AREG_W-1:0] cm_reg_idx,
  output logic [RET_W*DATA_W-1:0] cm_data,
  output logic [RET_W-1:0]        cm_st_req,
  output logic [RET_W*ADDR_W-1:0] cm_st_addr,
  output logic                    flush,
  output logic                    flush_exc
);
  logic             alloc_fire;
  logic [NR_W-1:0]  nret;
  logic [TAG_W-1:0] head_idx, tail_idx;
  logic [CNT_W-1:0] used;
  logic [RET_W-1:0] lane_rdy, lane_exc, lane_misp;
  logic [RET_W*2-1:0] lane_op, lane_dst;

  assign alloc_fire = alloc_valid && !full && !flush;
  assign alloc_tag  = tail_idx;

  rob_ptrs #(.DEPTH(DEPTH), .RET_W(RET_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .flush(flush),
    .nret(nret), .head_idx(head_idx), .tail_idx(tail_idx), .full(full),
    .used(used)
  );

  rob_entries #(.DEPTH(DEPTH), .RET_W(RET_W), .DATA_W(DATA_W),
                .ADDR_W(ADDR_W), .AREG_W(AREG_W)) u_entries (
    .clk(clk), .rst_n(rst_n), .alloc_we(alloc_fire), .alloc_idx(tail_idx),
    .alloc_op(alloc_op), .alloc_dst(alloc_dst), .alloc_areg(alloc_areg),
    .wb_we(wb_valid), .wb_idx(wb_tag), .wb_data(wb_data), .wb_addr(wb_addr),
    .wb_exc(wb_exc), .wb_misp(wb_misp), .head_idx(head_idx),
    .lane_tag(cm_tag), .lane_rdy(lane_rdy), .lane_exc(lane_exc),
    .lane_misp(lane_misp), .lane_op(lane_op), .lane_dst(lane_dst),
    .lane_areg(cm_reg_idx), .lane_data(cm_data), .lane_addr(cm_st_addr)
  );

  rob_retire #(.RET_W(RET_W), .CNT_W(CNT_W)) u_retire (
    .clk(clk), .rst_n(rst_n), .used(used), .lane_rdy(lane_rdy),
    .lane_exc(lane_exc), .lane_misp(lane_misp), .lane_op(lane_op),
    .lane_dst(lane_dst), .ret_valid(cm_valid), .reg_we(cm_reg_we),
    .st_req(cm_st_req), .flush(flush), .flush_exc(flush_exc), .nret(nret)
  );

  // R9: a request raised in a flush cycle leaves the queue empty
  p_alloc_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && flush) |=> (used == '0));

  // R2: an accepted allocation moves the tag by one slot
  p_tag_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && nret == '0) |=>
      (alloc_tag == (($past(alloc_tag) == TAG_W'(DEPTH-1)) ? '0 : $past(alloc_tag) + TAG_W'(1))));
endmodule

// File: tb/test_reorder_queue.sv
module test_reorder_queue;
  localparam int DEPTH = 40, RET_W = 3, DATA_W = 32, ADDR_W = 32, AREG_W = 4, TAG_W = 6;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic alloc_valid, wb_valid, wb_exc, wb_misp, full, flush, flush_exc;
  logic [1:0] alloc_op, alloc_dst;
  logic [AREG_W-1:0] alloc_areg;
  logic [TAG_W-1:0] alloc_tag, wb_tag;
  logic [DATA_W-1:0] wb_data;
  logic [ADDR_W-1:0] wb_addr;
  logic [RET_W-1:0] cm_valid, cm_reg_we, cm_st_req;
  logic [RET_W*TAG_W-1:0] cm_tag;
  logic [RET_W*AREG_W-1:0] cm_reg_idx;
  logic [RET_W*DATA_W-1:0] cm_data;
  logic [RET_W*ADDR_W-1:0] cm_st_addr;

  reorder_queue i_reorder_queue (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_op(alloc_op),
    .alloc_dst(alloc_dst), .alloc_areg(alloc_areg), .alloc_tag(alloc_tag),
    .full(full), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .wb_addr(wb_addr), .wb_exc(wb_exc), .wb_misp(wb_misp), .cm_valid(cm_valid),
    .cm_tag(cm_tag), .cm_reg_we(cm_reg_we), .cm_reg_idx(cm_reg_idx),
    .cm_data(cm_data), .cm_st_req(cm_st_req), .cm_st_addr(cm_st_addr),
    .flush(flush), .flush_exc(flush_exc)
  );

  int n_chk = 0, n_err = 0, burst3 = 0;
  bit done = 0;

  // bench model of the queue
  int m_op[DEPTH], m_dst[DEPTH], m_areg[DEPTH];
  logic [31:0] m_data[DEPTH], m_addr[DEPTH];
  bit m_rdy[DEPTH], m_exc[DEPTH], m_msp[DEPTH];
  int mq[$];
  int m_tail = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit av, int op, int dst, int areg,
                      bit wv, int wt, logic [31:0] wd, logic [31:0] wa, bit we, bit wm);
    bit [2:0] ev;
    bit fl, fx, stop, full_now;
    int n;
    @(negedge clk);
    alloc_valid = av; alloc_op = 2'(op); alloc_dst = 2'(dst); alloc_areg = 4'(areg);
    wb_valid = wv; wb_tag = 6'(wt); wb_data = wd; wb_addr = wa; wb_exc = we; wb_misp = wm;
    #1;
    full_now = (mq.size() == DEPTH);
    chk(full == full_now, "R3", "full", full, full_now);
    chk(alloc_tag == 6'(m_tail), "R2", "alloc_tag", alloc_tag, m_tail);
    ev = '0; fl = 0; fx = 0; stop = 0; n = 0;
    for (int i = 0; i < RET_W; i++) begin
      if (!stop && i < mq.size() && m_rdy[mq[i]]) begin
        int t;
        t = mq[i];
        if (m_exc[t]) begin fl = 1; fx = 1; stop = 1; end
        else begin
          ev[i] = 1; n++;
          chk(cm_tag[i*TAG_W +: TAG_W] == 6'(t), "R5", "lane tag", cm_tag[i*TAG_W +: TAG_W], t);
          chk(cm_reg_we[i] == (m_dst[t] == 1), "R6", "reg write enable", cm_reg_we[i], m_dst[t] == 1);
          chk(cm_st_req[i] == (m_dst[t] == 2), "R6", "store request", cm_st_req[i], m_dst[t] == 2);
          if (m_dst[t] == 1) begin
            chk(cm_reg_idx[i*AREG_W +: AREG_W] == 4'(m_areg[t]), "R6", "reg index",
                cm_reg_idx[i*AREG_W +: AREG_W], m_areg[t]);
            chk(cm_data[i*32 +: 32] == m_data[t], "R6", "reg data", cm_data[i*32 +: 32], m_data[t]);
          end
          if (m_dst[t] == 2) begin
            chk(cm_st_addr[i*32 +: 32] == m_addr[t], "R6", "store addr", cm_st_addr[i*32 +: 32], m_addr[t]);
            chk(cm_data[i*32 +: 32] == m_data[t], "R6", "store data", cm_data[i*32 +: 32], m_data[t]);
          end
          if (m_op[t] == 2 && m_msp[t]) begin fl = 1; stop = 1; end
        end
      end else stop = 1;
    end
    chk(cm_valid == ev, "R4", "retire lanes", cm_valid, ev);
    chk(flush == fl, "R7", "flush", flush, fl);
    chk(flush_exc == fx, "R8", "flush_exc", flush_exc, fx);
    if (ev == 3'b111) burst3++;
    // model update for the coming edge
    for (int i = 0; i < n; i++) void'(mq.pop_front());
    if (fl) begin
      m_tail = (mq.size() > 0) ? mq[0] : m_tail;
      mq.delete();
    end
    if (wv) begin
      m_rdy[wt] = 1; m_data[wt] = wd; m_addr[wt] = wa; m_exc[wt] = we; m_msp[wt] = wm;
    end
    if (av && !full_now && !fl) begin
      m_op[m_tail] = op; m_dst[m_tail] = dst; m_areg[m_tail] = areg;
      m_rdy[m_tail] = 0; m_exc[m_tail] = 0; m_msp[m_tail] = 0;
      mq.push_back(m_tail);
      m_tail = (m_tail + 1) % DEPTH;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, '0, '0, 0, 0);
  endtask
  task automatic alloc(int op, int dst, int areg);
    step(1, op, dst, areg, 0, 0, '0, '0, 0, 0);
  endtask
  task automatic wb(int t, logic [31:0] d, logic [31:0] a, bit e, bit m);
    step(0, 0, 0, 0, 1, t, d, a, e, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int tb, e1;
    void'($urandom(32'd20240611));
    rst_n = 0;
    alloc_valid = 0; alloc_op = 0; alloc_dst = 0; alloc_areg = 0;
    wb_valid = 0; wb_tag = 0; wb_data = 0; wb_addr = 0; wb_exc = 0; wb_misp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(full == 0, "R1", "full after reset", full, 0);
    chk(cm_valid == 0, "R1", "cm_valid after reset", cm_valid, 0);
    chk(flush == 0, "R1", "flush after reset", flush, 0);
    chk(alloc_tag == 0, "R1", "alloc_tag after reset", alloc_tag, 0);

    // fill all slots with a mix of destinations
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 7) alloc(1, 2, 0);
      else if (i == 9) alloc(0, 0, 0);
      else alloc(0, 1, i % 16);
    end
    alloc(0, 1, 3);
    chk(full == 1, "R3", "full with 40 slots", full, 1);
    idle();
    chk(alloc_tag == 0, "R3", "tag held while full", alloc_tag, 0);

    // young slot finishes first: head must block
    wb(5, 32'h105, 32'h1005, 0, 0);
    idle();
    chk(cm_valid == 0, "R4", "blocked behind unfinished head", cm_valid, 0);
    for (int t = 6; t < DEPTH; t++) wb(t, 32'h100 + t, 32'h1000 + t, 0, 0);
    for (int t = 4; t >= 0; t--) wb(t, 32'h100 + t, 32'h1000 + t, 0, 0);
    repeat (16) idle();
    chk(burst3 > 0, "R5", "three lanes retired in one cycle", burst3, 1);
    chk(cm_valid == 0 && full == 0, "R5", "queue drained", cm_valid, 0);

    // store destination
    tb = m_tail;
    alloc(1, 2, 0);
    wb(tb, 32'h55, 32'hABCD, 0, 0);
    idle();
    chk(cm_st_req[0] == 1, "R6", "store strobe", cm_st_req[0], 1);
    chk(cm_st_addr[31:0] == 32'hABCD, "R6", "store address", cm_st_addr[31:0], 32'hABCD);
    chk(cm_reg_we == 0, "R6", "no register write for store", cm_reg_we, 0);

    // mispredict flag on a register op
    tb = m_tail;
    alloc(0, 1, 2);
    wb(tb, 32'h77, 0, 0, 1);
    idle();
    chk(cm_valid[0] == 1 && flush == 0, "R10", "non-branch mispredict ignored",
        {cm_valid[0], flush}, 2'b10);

    // mispredicted branch with younger slots; allocation during flush
    alloc(0, 1, 1);
    tb = m_tail;
    alloc(2, 0, 0);
    alloc(0, 1, 4);
    alloc(0, 1, 5);
    wb((tb + 2) % DEPTH, 32'h3, 0, 0, 0);
    wb((tb + 1) % DEPTH, 32'h2, 0, 0, 0);
    wb(tb, 32'h0, 0, 0, 1);
    wb((tb + DEPTH - 1) % DEPTH, 32'h1, 0, 0, 0);
    step(1, 0, 1, 6, 0, 0, '0, '0, 0, 0);
    chk(flush == 1 && cm_valid == 3'b011, "R7", "branch retires and flushes",
        {flush, cm_valid}, 4'b1011);
    idle();
    chk(alloc_tag == 6'((tb + 1) % DEPTH), "R7", "tail restarts after branch", alloc_tag, (tb + 1) % DEPTH);
    chk(alloc_tag == 6'((tb + 1) % DEPTH) && cm_valid == 0, "R9", "allocation in flush cycle dropped",
        alloc_tag, (tb + 1) % DEPTH);

    // exception in the middle lane
    tb = m_tail;
    alloc(0, 1, 7);
    e1 = m_tail;
    alloc(0, 1, 8);
    alloc(0, 1, 9);
    wb((tb + 2) % DEPTH, 32'h9, 0, 0, 0);
    wb(e1, 32'h8, 0, 1, 0);
    wb(tb, 32'h7, 0, 0, 0);
    idle();
    chk(cm_reg_we == 3'b001 && flush_exc == 1 && flush == 1, "R8", "exception lane blocked",
        {cm_reg_we, flush, flush_exc}, 5'b00111);
    idle();
    chk(alloc_tag == 6'(e1), "R8", "tail restarts at excepting slot", alloc_tag, e1);

    // randomized out-of-order writeback
    for (int k = 0; k < 4000; k++) begin
      int r, op, dst, wt;
      bit av, wv, we, wm;
      int cand[$];
      av = ($urandom % 100) < 55;
      r = $urandom % 10;
      if (r < 6) begin op = 0; dst = 1; end
      else if (r < 8) begin op = 1; dst = 2; end
      else if (r == 8) begin op = 2; dst = 0; end
      else begin op = 0; dst = 0; end
      foreach (mq[q]) if (!m_rdy[mq[q]]) cand.push_back(mq[q]);
      wv = 0; wt = 0; we = 0; wm = 0;
      if (cand.size() > 0 && ($urandom % 100) < 60) begin
        wv = 1;
        wt = cand[$urandom % cand.size()];
        we = ($urandom % 60) == 0;
        wm = (m_op[wt] == 2) ? (($urandom % 4) == 0) : (($urandom % 40) == 0);
      end
      step(av, op, dst, $urandom % 16, wv, wt, $urandom, $urandom, we, wm);
    end
    for (int k = 0; k < 300; k++) begin
      int cand[$];
      foreach (mq[q]) if (!m_rdy[mq[q]]) cand.push_back(mq[q]);
      if (cand.size() > 0) wb(cand[0], $urandom, $urandom, 0, 0);
      else idle();
    end
    chk(cm_valid == 0 && full == 0, "R4", "final drain", cm_valid, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule